// File: doc/BRIEF.md
# GPIO Edge-Detect and Interrupt Unit

This unit watches 128 general-purpose pins, organised as four banks of 32. It compares each pin with its level on the previous clock to find edges. A sticky status bit is set for a pin when the edge matches that pin's enables and the pin is configured as an input. The per-pin direction, rising-enable and falling-enable masks come from the register block. The bus clears status bits one bank at a time by writing a mask in which each 1 clears the matching bit.

The status bits are combined into three registered interrupt levels. Pin 0 and pin 1 each have a dedicated line. The third line is the OR of every other status bit. While the processor is halted, a level change on an input pin that is selected by a fixed wake mask produces a one-cycle wake request. The pin inputs must already be synchronised to the clock.

Top module: `gpio_edge_irq`

## Requirements
- R1: A pin configured as an input (direction bit 0) whose rising enable is 1 sets its status bit when its sampled level goes from 0 to 1. The bit is visible on `status_o` after the clock edge that first samples the new level.
- R2: A pin configured as an input whose falling enable is 1 sets its status bit when its sampled level goes from 1 to 0, with the same timing as R1.
- R3: A pin configured as an output (direction bit 1) never sets its status bit, whatever its enables are. An edge whose own enable is 0 sets nothing.
- R4: Status bits are sticky and hold until cleared. A clear write with `clr_valid` high clears, in bank `clr_bank` (pins 32*clr_bank to 32*clr_bank+31), each bit whose `clr_data` bit is 1. All other bits, and all other banks, keep their value.
- R5: `irq_pin0_o` and `irq_pin1_o` equal status bits 0 and 1, one clock after the status bit changes.
- R6: `irq_other_o` is the OR of status bits 2 to 127, one clock after the status bits change.
- R7: When `halted_i` is 1 and an input pin whose wake-mask bit is 1 changes level, `wake_o` is high for exactly one cycle, at the same time as a status update would appear. The per-bank masks, with bank 0 holding pins 0..31, are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F. There is no wake request while not halted, for output pins, or for pins whose mask bit is 0.
- R8: If a qualifying edge and a clear for the same bit arrive in the same cycle, the edge wins and the bit stays set.
- R9: During reset and after it, all status bits, interrupt outputs and the wake request are 0. The previous level of every pin is taken as 0 at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 128 | Synchronised pin levels |
| dir_i | input | 128 | Direction mask, 1 = output |
| rise_en_i | input | 128 | Rising-edge enable per pin |
| fall_en_i | input | 128 | Falling-edge enable per pin |
| clr_valid | input | 1 | Clear write strobe |
| clr_bank | input | 2 | Bank addressed by the clear write |
| clr_data | input | 32 | Write-1-to-clear mask |
| halted_i | input | 1 | Processor halted |
| status_o | output | 128 | Sticky edge-status bits |
| irq_pin0_o | output | 1 | Interrupt for pin 0 |
| irq_pin1_o | output | 1 | Interrupt for pin 1 |
| irq_other_o | output | 1 | Combined interrupt for pins 2..127 |
| wake_o | output | 1 | One-cycle wake request |

## Verification
The assertions assume that the direction, enable and halted inputs hold steady across the cycle in which an edge is qualified. They also assume that the pins are already synchronous, so each sampled level is a clean 0 or 1. The stimulus respects this. It changes pins, masks and strobes only on the falling clock edge, sets up each pin's configuration several cycles before the transition under test, and drives every input to a known value from time zero.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int NBANK  = 4;
  localparam int BANK_W = 32;
  localparam int NPINS  = NBANK * BANK_W;
  localparam int BANK_SEL_W = $clog2(NBANK);
  typedef logic [BANK_W-1:0] bank_word_t;
  localparam logic [NPINS-1:0] DEFAULT_WAKE =
    {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B};
endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int W = BANK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] change_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] status_q, status_d;
  logic [W-1:0] rise_hit, fall_hit, edge_hit;

  always_comb begin
    change_o = pin_i ^ prev_q;
    rise_hit = pin_i & ~prev_q & rise_en_i;
    fall_hit = ~pin_i & prev_q & fall_en_i;
    edge_hit = (rise_hit | fall_hit) & ~dir_i;
    status_d = (status_q & ~clr_i) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= pin_i;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  // R3
  out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & $past(dir_i)) == '0));
  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_q) & ~$past(clr_i) & ~status_q) == '0));
  // R8
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(edge_hit) & ~status_q) == '0));
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine
  import gpio_edge_pkg::*;
#(
  parameter int N = NPINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status_i,
  output logic         irq0_o,
  output logic         irq1_o,
  output logic         irq_other_o
);
  logic irq0_d, irq1_d, other_d;
  logic irq0_q, irq1_q, other_q;

  always_comb begin
    irq0_d  = status_i[0];
    irq1_d  = status_i[1];
    other_d = |status_i[N-1:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0_q  <= 1'b0;
      irq1_q  <= 1'b0;
      other_q <= 1'b0;
    end else begin
      irq0_q  <= irq0_d;
      irq1_q  <= irq1_d;
      other_q <= other_d;
    end
  end

  assign irq0_o      = irq0_q;
  assign irq1_o      = irq1_q;
  assign irq_other_o = other_q;

  // R5
  irq_pin0_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq0_o == $past(status_i[0]));
  // R5
  irq_pin1_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq1_o == $past(status_i[1]));
  // R6
  irq_other_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_other_o == (|$past(status_i[N-1:2])));
endmodule

// File: rtl/gpio_wake_gen.sv
module gpio_wake_gen
  import gpio_edge_pkg::*;
#(
  parameter int               N    = NPINS,
  parameter logic [N-1:0]     MASK = DEFAULT_WAKE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] change_i,
  input  logic [N-1:0] dir_i,
  input  logic         halted_i,
  output logic         wake_o
);
  logic wake_d, wake_q;

  always_comb begin
    wake_d = halted_i & (|(change_i & ~dir_i & MASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wake_o = wake_q;

  // R7
  wake_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(halted_i));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter logic [NPINS-1:0] WAKE_MASK = DEFAULT_WAKE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      pin_i,
  input  logic [NPINS-1:0]      dir_i,
  input  logic [NPINS-1:0]      rise_en_i,
  input  logic [NPINS-1:0]      fall_en_i,
  input  logic                  clr_valid,
  input  logic [BANK_SEL_W-1:0] clr_bank,
  input  logic [BANK_W-1:0]     clr_data,
  input  logic                  halted_i,
  output logic [NPINS-1:0]      status_o,
  output logic                  irq_pin0_o,
  output logic                  irq_pin1_o,
  output logic                  irq_other_o,
  output logic                  wake_o
);
  logic [NPINS-1:0] status_all;
  logic [NPINS-1:0] change_all;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    bank_word_t clr_b;
    always_comb begin
      clr_b = (clr_valid && (clr_bank == BANK_SEL_W'(b))) ? clr_data : '0;
    end
    gpio_edge_bank #(.W(BANK_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin_i[LO +: BANK_W]),
      .dir_i     (dir_i[LO +: BANK_W]),
      .rise_en_i (rise_en_i[LO +: BANK_W]),
      .fall_en_i (fall_en_i[LO +: BANK_W]),
      .clr_i     (clr_b),
      .status_o  (status_all[LO +: BANK_W]),
      .change_o  (change_all[LO +: BANK_W])
    );
  end

  gpio_irq_combine #(.N(NPINS)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_i    (status_all),
    .irq0_o      (irq_pin0_o),
    .irq1_o      (irq_pin1_o),
    .irq_other_o (irq_other_o)
  );

  gpio_wake_gen #(.N(NPINS), .MASK(WAKE_MASK)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .change_i (change_all),
    .dir_i    (dir_i),
    .halted_i (halted_i),
    .wake_o   (wake_o)
  );

  assign status_o = status_all;

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (status_o == '0 && !irq_pin0_o && !irq_pin1_o && !irq_other_o && !wake_o));
endmodule

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;
  import gpio_edge_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                  rst_n;
  logic [NPINS-1:0]      pins, dirs, rises, falls;
  logic                  clr_valid;
  logic [BANK_SEL_W-1:0] clr_bank;
  logic [BANK_W-1:0]     clr_data;
  logic                  halted;
  logic [NPINS-1:0]      status;
  logic                  irq0, irq1, irqx, wake;

  gpio_edge_irq uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .dir_i(dirs),
    .rise_en_i(rises), .fall_en_i(falls), .clr_valid(clr_valid),
    .clr_bank(clr_bank), .clr_data(clr_data), .halted_i(halted),
    .status_o(status), .irq_pin0_o(irq0), .irq_pin1_o(irq1),
    .irq_other_o(irqx), .wake_o(wake)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string tag, input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int b = 0; b < NBANK; b++) begin
      clr_valid = 1'b1; clr_bank = BANK_SEL_W'(b); clr_data = '1;
      tick(1);
    end
    clr_valid = 1'b0; clr_data = '0;
  endtask

  // {pin[6:0], dir, rise_en, fall_en, start level, end level, expected status}
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    {7'd0,   6'b010011},  // R1 pin0 rising
    {7'd1,   6'b001101},  // R2 pin1 falling
    {7'd2,   6'b010011},  // R1 R6 pin2 rising
    {7'd40,  6'b001101},  // R2 bank1 falling
    {7'd127, 6'b011011},  // R1 last pin
    {7'd64,  6'b111010},  // R3 output pin
    {7'd70,  6'b001010},  // R3 rising with only falling enabled
    {7'd31,  6'b010100},  // R3 falling with only rising enabled
    {7'd96,  6'b101100},  // R3 output falling
    {7'd33,  6'b011101}   // R2 both enabled
  };

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pins = '0; dirs = '0; rises = '0; falls = '0;
    clr_valid = 1'b0; clr_bank = '0; clr_data = '0; halted = 1'b0;
    tick(3);
    chk("R9 status in reset", status, '0);
    chk("R9 irq/wake in reset", {124'b0, irq0, irq1, irqx, wake}, '0);
    rst_n = 1'b1;
    tick(2);
    chk("R9 status after reset", status, '0);
    chk("R9 outputs after reset", {124'b0, irq0, irq1, irqx, wake}, '0);

    for (int v = 0; v < NV; v++) begin
      int p;
      logic x;
      p = int'(VEC[v][12:6]);
      x = VEC[v][0];
      pins = '0; dirs = '0; rises = '0; falls = '0;
      dirs[p] = VEC[v][5]; rises[p] = VEC[v][4]; falls[p] = VEC[v][3];
      pins[p] = VEC[v][2];
      tick(3);
      clear_all();
      tick(2);
      pins[p] = VEC[v][1];
      tick(1);
      chk($sformatf("R1 R2 R3 status vector %0d", v), status, NPINS'(x) << p);
      tick(1);
      chk($sformatf("R5 R6 irq vector %0d", v), {125'b0, irq0, irq1, irqx},
          {125'b0, x && p == 0, x && p == 1, x && p >= 2});
    end

    // Wake request
    pins = '0; dirs = '0; rises = '0; falls = '0;
    tick(3);
    halted = 1'b1; pins[0] = 1'b1;
    tick(1); chk("R7 wake on masked pin 0", NPINS'(wake), NPINS'(1));
    tick(1); chk("R7 wake is one cycle", NPINS'(wake), '0);
    pins[2] = 1'b1;
    tick(1); chk("R7 no wake on unmasked pin 2", NPINS'(wake), '0);
    halted = 1'b0; pins[3] = 1'b1;
    tick(1); chk("R7 no wake when not halted", NPINS'(wake), '0);
    halted = 1'b1; dirs[4] = 1'b1; pins[4] = 1'b1;
    tick(1); chk("R7 no wake on output pin", NPINS'(wake), '0);
    pins[96] = 1'b1;
    tick(1); chk("R7 wake on masked pin 96", NPINS'(wake), NPINS'(1));
    halted = 1'b0;

    // Sticky, per-bank clear, edge-over-clear
    pins = '0; dirs = '0; rises = '0; falls = '0;
    rises[5] = 1'b1; rises[7] = 1'b1;
    tick(3); clear_all(); tick(2);
    pins[5] = 1'b1; pins[7] = 1'b1;
    tick(1); chk("R1 bits 5 and 7 set", status, (NPINS'(1) << 5) | (NPINS'(1) << 7));
    pins[5] = 1'b0; pins[7] = 1'b0;
    tick(2); chk("R4 sticky after pins fall", status, (NPINS'(1) << 5) | (NPINS'(1) << 7));
    clr_valid = 1'b1; clr_bank = 2'd1; clr_data = '1;
    tick(1); clr_valid = 1'b0;
    chk("R4 clear of other bank ignored", status, (NPINS'(1) << 5) | (NPINS'(1) << 7));
    clr_valid = 1'b1; clr_bank = 2'd0; clr_data = 32'h80;
    tick(1); clr_valid = 1'b0;
    chk("R4 clear bit 7 only", status, NPINS'(1) << 5);
    pins[5] = 1'b1; clr_valid = 1'b1; clr_bank = 2'd0; clr_data = 32'h20;
    tick(1); clr_valid = 1'b0;
    chk("R8 edge wins over clear", status, NPINS'(1) << 5);
    clr_valid = 1'b1; clr_data = 32'h20;
    tick(1); clr_valid = 1'b0;
    chk("R4 clear bit 5", status, '0);
    tick(1);
    chk("R6 irq drops after clear", {125'b0, irq0, irq1, irqx}, '0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule